// File: doc/BRIEF.md
# Serial-MAC Low-Pass FIR Filter

This block is a 31-tap low-pass finite impulse response filter for an audio path that runs at about 48 kHz. A one-cycle strobe delivers each new 8-bit signed sample. The block keeps the recent sample history in a 32-entry circular buffer. It then computes the weighted sum with one multiplier and one accumulator, taking one tap per clock during the quiet time before the next strobe.

The coefficient set is fixed and symmetric. Its integer values are scaled by 1024 and give a normalised cutoff of 0.125, which is about 3 kHz at 48 kHz. The output is an 18-bit signed word that still carries the 1024 gain, so a consumer that wants an 8-bit result takes bits 17 down to 10. On each strobe the output register takes the sum finished for the previous sample. The value seen at any strobe is therefore complete and stays stable until the next strobe.

Top module: `fir_lp_top`

## Requirements
- R1: While `rst_ni` is low, and after its release up to the first strobe, `result_o` is 0. An asynchronous reset at any time clears the whole sample history, so later sums treat all earlier samples as 0.
- R2: Tap k applies to the sample received k strobes before the newest one. Its weight is c[k]. The weight is 128 at k=15, and c[15-d] equals c[15+d]. For d=1 through 15 the weights are 123, 110, 91, 69, 46, 26, 10, 0, -5, -7, -6, -5, -3, -1, -1.
- R3: Number the strobes n = 0, 1, 2 and so on, and let x[n] be the sample taken at strobe n. Right after strobe n, `result_o` equals the low 18 bits, in two's complement, of the sum of c[k]*x[n-1-k] for k = 0 to 30. Any x with a negative index counts as 0.
- R4: `result_o` changes only on the clock edge where `strobe_i` is high. Between strobes it holds its value.
- R5: Feed a single sample A into zero history and then feed zeros. The outputs after the following 31 strobes are A*c[0] through A*c[30], in that order, and the output after that is 0.
- R6: A constant input A held for at least 31 strobes settles to 1022*A. This gives 129794 for A=127 and -130816 for A=-128.
- R7: The accumulation pass starts on the cycle after a strobe and takes exactly 31 cycles. Strobes spaced exactly 32 cycles apart therefore give exact results. Strobes spaced closer than 32 cycles are outside the contract.
- R8: The history pointer wraps modulo 32. Results stay exact over runs much longer than 32 strobes, with irregular gaps between strobes.
- R9: The internal sum is 23 bits wide and does not overflow. The output is the wrapped low 18 bits of that sum and is never saturated. For example, +127 on every non-negative tap and -128 on every negative tap gives the true sum 144074, which appears as -118070.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | One-cycle marker of a new input sample |
| sample_i | input | 8 | Signed input sample, captured when `strobe_i` is high |
| result_o | output | 18 | Signed filter output with a gain of 1024 |

## Verification
The impulse run is aimed at an indexing fault. A read pointer that is off by one, or a mirrored table that is wrong, shows up as a shifted or corrupted coefficient sequence. The strobes in that run are exactly 32 cycles apart, so a pass that takes one cycle too many presents a sum with a tap missing. The wrap pattern pushes the true sum beyond 18 bits, so a narrow accumulator or a saturating output gives a value other than -118070. A reset in the middle of a stream followed by a fresh impulse exposes any history that the reset left behind. A long random run with irregular gaps tests the pointer wrap.

// File: rtl/fir_lp_pkg.sv
package fir_lp_pkg;
  localparam int TAPS   = 31;
  localparam int COEF_W = 10;
  localparam int MID    = (TAPS - 1) / 2;

  typedef logic signed [COEF_W-1:0] coef_t;

  // Half table; upper taps mirror around MID.
  function automatic coef_t coef_at(input int unsigned k);
    int unsigned d;
    d = (k > MID) ? (k - MID) : (MID - k);
    case (d)
      0:  coef_at = 10'sd128;
      1:  coef_at = 10'sd123;
      2:  coef_at = 10'sd110;
      3:  coef_at = 10'sd91;
      4:  coef_at = 10'sd69;
      5:  coef_at = 10'sd46;
      6:  coef_at = 10'sd26;
      7:  coef_at = 10'sd10;
      8:  coef_at = 10'sd0;
      9:  coef_at = -10'sd5;
      10: coef_at = -10'sd7;
      11: coef_at = -10'sd6;
      12: coef_at = -10'sd5;
      13: coef_at = -10'sd3;
      14: coef_at = -10'sd1;
      15: coef_at = -10'sd1;
      default: coef_at = '0;
    endcase
  endfunction
endpackage

// File: rtl/fir_coef_rom.sv
module fir_coef_rom
  import fir_lp_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic [TAP_W-1:0] tap_i,
  output coef_t            coef_o
);
  always_comb coef_o = coef_at(32'(tap_i));
endmodule

// File: rtl/fir_sample_ring.sv
module fir_sample_ring #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     wr_en_i,
  input  logic signed [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0]        rd_lag_i,
  output logic signed [DATA_W-1:0] rd_data_o,
  output logic [ADDR_W-1:0]        wptr_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic signed [DATA_W-1:0] mem_q [DEPTH];
  logic [ADDR_W-1:0]        wptr_q;
  logic [ADDR_W-1:0]        rd_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (wr_en_i) begin
      mem_q[wptr_q] <= wr_data_i;
      wptr_q        <= wptr_q + ADDR_W'(1);
    end
  end

  // newest sample sits one behind the write pointer
  assign rd_addr   = wptr_q - ADDR_W'(1) - rd_lag_i;
  assign rd_data_o = mem_q[rd_addr];
  assign wptr_o    = wptr_q;
endmodule

// File: rtl/fir_mac_seq.sv
module fir_mac_seq #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 10,
  parameter int TAPS   = 31,
  parameter int TAP_W  = 5,
  parameter int ACC_W  = 23
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     start_i,
  input  logic signed [DATA_W-1:0] sample_i,
  input  logic signed [COEF_W-1:0] coef_i,
  output logic [TAP_W-1:0]         tap_o,
  output logic                     busy_o,
  output logic signed [ACC_W-1:0]  acc_o
);
  localparam int PROD_W = DATA_W + COEF_W;
  localparam logic [TAP_W-1:0] LAST = TAP_W'(TAPS - 1);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;
  logic [TAP_W-1:0]         tap_q;
  logic                     busy_q;

  assign prod     = sample_i * coef_i;
  assign prod_ext = {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tap_q  <= '0;
      busy_q <= 1'b0;
    end else if (start_i) begin
      acc_q  <= '0;
      tap_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      acc_q <= acc_q + prod_ext;
      if (tap_q == LAST) busy_q <= 1'b0;
      else               tap_q  <= tap_q + TAP_W'(1);
    end
  end

  assign tap_o  = tap_q;
  assign busy_o = busy_q;
  assign acc_o  = acc_q;
endmodule

// File: rtl/fir_lp_top.sv
module fir_lp_top
  import fir_lp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OUT_W  = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    strobe_i,
  input  logic signed [DATA_W-1:0] sample_i,
  output logic signed [OUT_W-1:0]  result_o
);
  localparam int ADDR_W = $clog2(TAPS + 1);
  localparam int ACC_W  = DATA_W + COEF_W + $clog2(TAPS);

  logic [ADDR_W-1:0]        tap;
  logic [ADDR_W-1:0]        wptr;
  logic                     busy;
  logic signed [DATA_W-1:0] hist_sample;
  coef_t                    coef;
  logic signed [ACC_W-1:0]  acc;
  logic signed [OUT_W-1:0]  result_q;
  logic                     unused_hi;

  fir_sample_ring #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) ring_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (strobe_i),
    .wr_data_i (sample_i),
    .rd_lag_i  (tap),
    .rd_data_o (hist_sample),
    .wptr_o    (wptr)
  );

  fir_coef_rom #(.TAP_W(ADDR_W)) rom_i (
    .tap_i  (tap),
    .coef_o (coef)
  );

  fir_mac_seq #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W),
    .TAPS   (TAPS),
    .TAP_W  (ADDR_W),
    .ACC_W  (ACC_W)
  ) mac_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (strobe_i),
    .sample_i (hist_sample),
    .coef_i   (coef),
    .tap_o    (tap),
    .busy_o   (busy),
    .acc_o    (acc)
  );

  // publish the finished sum of the previous sample on each strobe
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       result_q <= '0;
    else if (strobe_i) result_q <= acc[OUT_W-1:0];
  end

  assign unused_hi = ^acc[ACC_W-1:OUT_W];
  assign result_o  = result_q;
endmodule

// File: rtl/fir_lp_checker.sv
module fir_lp_checker #(
  parameter int ADDR_W = 5,
  parameter int TAPS   = 31,
  parameter int OUT_W  = 18
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              strobe_i,
  input logic [OUT_W-1:0]  result_o,
  input logic              busy,
  input logic [ADDR_W-1:0] tap,
  input logic [ADDR_W-1:0] wptr
);
  a_r4_hold_between: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(result_o));

  a_r7_pass_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (busy && tap == '0));

  a_r7_pass_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && tap == ADDR_W'(TAPS - 1) && !strobe_i) |=> !busy);

  a_r7_tap_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> (tap <= ADDR_W'(TAPS - 1)));

  a_r7_strobe_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !strobe_i);

  a_r8_wptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    strobe_i |=> (wptr == $past(wptr) + ADDR_W'(1)));

  a_r8_wptr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> $stable(wptr));
endmodule

bind fir_lp_top fir_lp_checker chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .strobe_i (strobe_i),
  .result_o (result_o),
  .busy     (busy),
  .tap      (tap),
  .wptr     (wptr)
);

// File: tb/fir_lp_top_tb_top.sv
`timescale 1ns/1ps
module fir_lp_top_tb_top;
  logic clk = 1'b0;
  logic rst_ni;
  logic strobe;
  logic signed [7:0]  sample;
  logic signed [17:0] result;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R3";

  int coef_tb [31] = '{-1, -1, -3, -5, -6, -7, -5, 0, 10, 26, 46, 69, 91, 110, 123,
                       128, 123, 110, 91, 69, 46, 26, 10, 0, -5, -7, -6, -5, -3, -1, -1};

  always #2.5 clk = ~clk;

  fir_lp_top dut_i (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .strobe_i (strobe),
    .sample_i (sample),
    .result_o (result)
  );

  // behavioural reference: history queue, full convolution per strobe
  int hist[$];
  int pend;
  logic signed [17:0] exp_q;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      hist.delete();
      pend  = 0;
      exp_q <= '0;
    end else if (strobe) begin
      exp_q <= 18'(pend);
      hist.push_front(int'(sample));
      if (hist.size() > 31) void'(hist.pop_back());
      pend = 0;
      foreach (hist[k]) pend += coef_tb[k] * hist[k];
    end
  end

  // per-clock comparison against the model (R3)
  always @(negedge clk) begin
    if (rst_ni === 1'b1) begin
      checks++;
      if (result !== exp_q) begin
        fails++;
        $display("FAIL %s cycle-compare result_o=%0d expected=%0d", cur_req, result, exp_q);
      end
    end
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // one strobe, then hold for gap-1 more cycles; R4 checked at the end
  task automatic send(input int s, input int gap);
    int held;
    @(negedge clk);
    strobe = 1'b1;
    sample = 8'(s);
    @(negedge clk);
    strobe = 1'b0;
    held = int'(result);
    repeat (gap - 1) @(negedge clk);
    chk("R4", int'(result), held);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(150000 * 5);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_ni = 1'b0;
    strobe = 1'b0;
    sample = '0;
    repeat (3) @(negedge clk);
    chk("R1", int'(result), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", int'(result), 0);

    // R5 R2 R7: impulse, strobes exactly 32 cycles apart
    cur_req = "R5";
    send(100, 32);
    chk("R3", int'(result), 0);
    for (int k = 0; k < 31; k++) begin
      send(0, 32);
      chk("R5 R2 R7", int'(result), 100 * coef_tb[k]);
    end
    send(0, 32);
    chk("R5", int'(result), 0);

    // R6: positive and negative full-scale steps
    cur_req = "R6";
    for (int i = 0; i < 33; i++) send(127, 33);
    chk("R6", int'(result), 129794);
    for (int i = 0; i < 33; i++) send(-128, 34);
    chk("R6", int'(result), -130816);

    // R9: sign-matched extreme pattern wraps the 18-bit output
    cur_req = "R9";
    for (int j = 0; j < 31; j++) send((coef_tb[30 - j] < 0) ? -128 : 127, 32);
    send(0, 32);
    chk("R9", int'(result), -118070);

    // R8: long random run with irregular gaps
    cur_req = "R8";
    for (int i = 0; i < 120; i++)
      send(int'($urandom_range(0, 255)) - 128, int'($urandom_range(32, 45)));
    chk("R8", int'(result), int'(exp_q));

    // R1: mid-stream reset wipes history
    cur_req = "R1";
    @(negedge clk);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1", int'(result), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    send(50, 32);
    chk("R1", int'(result), 0);
    send(0, 32);
    chk("R1", int'(result), 50 * coef_tb[0]);
    send(0, 32);
    chk("R1", int'(result), 50 * coef_tb[1]);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule